// File: doc/BRIEF.md
# Multiplexed External Bus Timing Generator

This block produces the address latch enable and the phase controls for an 8-bit multiplexed address/data bus, one 16-bit access per machine cycle. A machine cycle is four oscillator periods. The block is clocked at twice the oscillator rate, so each clock is one half oscillator period. A free-running half-clock counter divides every machine cycle into eight half-clocks. ALE is built from that counter, which gives its 1.5-oscillator-cycle width without using both clock edges.

A request and its address are sampled in the last half-clock of a machine cycle. The access then fills the whole next machine cycle. In that cycle the low address byte is put on the shared bus while ALE is high. When ALE falls, the bus is handed over to the data phase. The high address byte is held on a separate output for the whole cycle. A park control keeps ALE high with no pulses to reduce emissions, but it gives way to normal pulses in any cycle that carries an access.

Top module: `mux_bus_timing`

## Requirements
- R1: A machine cycle is 8 clocks (half-clocks 0 to 7). ALE is high in half-clocks 0 to 2 and low in half-clocks 3 to 7, so it rises at the start of half-clock 0 and falls three half-clocks later.
- R2: While rst_ni is low, the outputs take fixed values at once, with no clock needed: ale_o=1, ad_oe_o=0, data_phase_o=0, ad_addr_o=0 and addr_hi_o=0. The first machine cycle after release starts at half-clock 0, is idle and pulses ALE normally. The park control resets to 0.
- R3: In an idle machine cycle that was started with ale_off_i=1, ale_o stays 1 for all 8 half-clocks.
- R4: In an access cycle, ALE pulses as in R1 even when ale_off_i=1.
- R5: req_i, ale_off_i and addr_i are sampled only in half-clock 7 and set up the following machine cycle. A change to them in any other half-clock has no effect on the cycle in progress.
- R6: In half-clocks 0 to 2 of an access cycle, ad_oe_o=1 and ad_addr_o carries address bits 7:0. At all other times ad_oe_o=0 and ad_addr_o=0.
- R7: data_phase_o=1 in half-clocks 3 to 7 of an access cycle and 0 at all other times. It is never 1 together with ad_oe_o.
- R8: addr_hi_o carries address bits 15:8 in all 8 half-clocks of an access cycle and is 0 in idle cycles.
- R9: Accesses in back-to-back machine cycles each show their own address, with no idle half-clock between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at twice the oscillator rate (one half-clock per period) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ale_off_i | input | 1 | Park ALE high in idle cycles |
| req_i | input | 1 | External access request for the next machine cycle |
| addr_i | input | 16 | Access address |
| ale_o | output | 1 | Address latch enable |
| ad_oe_o | output | 1 | Drive enable for the low address byte on the multiplexed bus |
| ad_addr_o | output | 8 | Low address byte for the multiplexed bus |
| addr_hi_o | output | 8 | High address byte |
| data_phase_o | output | 1 | Multiplexed bus is in its data phase |

## Verification
The bench builds the block with its default parameters: four oscillator clocks per machine cycle, a three-half-clock ALE window and a 16-bit address split 8/8. This gives an eight-half-clock frame, and each table row gives its expected outputs as per-half-clock bit masks. With these values, every half-clock of idle, parked, parked-with-access and back-to-back access cycles can be checked one by one. Inputs that change in the middle of a cycle, and an asynchronous reset in the middle of an access, can also be placed at known half-clocks.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } bus_phase_e;
endpackage

// File: rtl/ebus_half_ctr.sv
module ebus_half_ctr #(
  parameter int HALF_PER_MC = 8,
  localparam int CNT_W = $clog2(HALF_PER_MC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  assign last_o = (cnt_q == CNT_W'(HALF_PER_MC - 1));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (last_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assert_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (cnt_o == '0));

  assert_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_o |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/ebus_cycle_latch.sv
module ebus_cycle_latch #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              last_i,
  input  logic              req_i,
  input  logic              ale_off_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              acc_o,
  output logic              off_o,
  output logic [ADDR_W-1:0] addr_o
);
  // Request, park control and address are all taken at the cycle boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o  <= 1'b0;
      off_o  <= 1'b0;
      addr_o <= '0;
    end else if (last_i) begin
      acc_o  <= req_i;
      off_o  <= ale_off_i;
      addr_o <= addr_i;
    end
  end

  assert_hold_mid_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_i |=> ($stable(acc_o) && $stable(off_o) && $stable(addr_o)));
endmodule

// File: rtl/ebus_phase_dec.sv
module ebus_phase_dec
  import ebus_pkg::*;
#(
  parameter int CNT_W    = 3,
  parameter int ALE_HALF = 3,
  parameter int ADDR_W   = 16,
  parameter int LO_W     = 8,
  localparam int HI_W    = ADDR_W - LO_W
) (
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              acc_i,
  input  logic              off_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ale_o,
  output logic              ad_oe_o,
  output logic [LO_W-1:0]   ad_addr_o,
  output logic [HI_W-1:0]   addr_hi_o,
  output logic              data_phase_o
);
  logic       ale_win;
  bus_phase_e phase;

  assign ale_win = (cnt_i < CNT_W'(ALE_HALF));

  always_comb begin
    if (!acc_i)       phase = PH_IDLE;
    else if (ale_win) phase = PH_ADDR;
    else              phase = PH_DATA;
  end

  // Parking only applies to idle cycles; an access always pulses
  assign ale_o        = ale_win || (off_i && (phase == PH_IDLE));
  assign ad_oe_o      = (phase == PH_ADDR);
  assign data_phase_o = (phase == PH_DATA);
  assign ad_addr_o    = ad_oe_o ? addr_i[LO_W-1:0] : '0;
  assign addr_hi_o    = acc_i ? addr_i[ADDR_W-1:LO_W] : '0;
endmodule

// File: rtl/mux_bus_timing.sv
module mux_bus_timing #(
  parameter int OSC_PER_MC = 4,
  parameter int ALE_HALF   = 3,
  parameter int ADDR_W     = 16,
  parameter int LO_W       = 8,
  localparam int HALF_PER_MC = 2 * OSC_PER_MC,
  localparam int CNT_W       = $clog2(HALF_PER_MC),
  localparam int HI_W        = ADDR_W - LO_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ale_off_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ale_o,
  output logic              ad_oe_o,
  output logic [LO_W-1:0]   ad_addr_o,
  output logic [HI_W-1:0]   addr_hi_o,
  output logic              data_phase_o
);
  logic [CNT_W-1:0]  cnt;
  logic              last;
  logic              acc_q;
  logic              off_q;
  logic [ADDR_W-1:0] addr_q;

  ebus_half_ctr #(.HALF_PER_MC(HALF_PER_MC)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt),
    .last_o (last)
  );

  ebus_cycle_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .last_i    (last),
    .req_i     (req_i),
    .ale_off_i (ale_off_i),
    .addr_i    (addr_i),
    .acc_o     (acc_q),
    .off_o     (off_q),
    .addr_o    (addr_q)
  );

  ebus_phase_dec #(
    .CNT_W    (CNT_W),
    .ALE_HALF (ALE_HALF),
    .ADDR_W   (ADDR_W),
    .LO_W     (LO_W)
  ) u_dec (
    .cnt_i        (cnt),
    .acc_i        (acc_q),
    .off_i        (off_q),
    .addr_i       (addr_q),
    .ale_o        (ale_o),
    .ad_oe_o      (ad_oe_o),
    .ad_addr_o    (ad_addr_o),
    .addr_hi_o    (addr_hi_o),
    .data_phase_o (data_phase_o)
  );

  // Sampled on the falling edge so that registers have settled after reset
  assert_reset_values_R2: assert property (@(negedge clk_i)
    !rst_ni |-> (ale_o && !ad_oe_o && !data_phase_o && addr_hi_o == '0));

  assert_ale_rise_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ale_o) |-> (cnt == '0));

  assert_ale_fall_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ale_o) |-> (cnt == CNT_W'(ALE_HALF)));

  assert_parked_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_q && !acc_q) |-> ale_o);

  assert_addr_under_ale_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> ale_o);

  assert_phase_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ad_oe_o && data_phase_o));

  assert_hi_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q && cnt != '0) |-> $stable(addr_hi_o));
endmodule

// File: tb/sim_mux_bus_timing.sv
module sim_mux_bus_timing;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        req;
    logic        off;
    logic        glitch;
    logic [15:0] addr;
    logic [7:0]  ale_m;
    logic [7:0]  oe_m;
    logic [7:0]  dp_m;
  } vec_t;

  localparam logic [7:0] AN  = 8'h07;
  localparam logic [7:0] AP  = 8'hFF;
  localparam logic [7:0] OEA = 8'h07;
  localparam logic [7:0] DPA = 8'hF8;

  localparam vec_t IDLE = '{1'b0, 1'b0, 1'b0, 16'h0000, AN, 8'h00, 8'h00};

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 1'b0, 16'h0000, AN, 8'h00, 8'h00},
    '{1'b1, 1'b0, 1'b0, 16'h1234, AN, OEA,   DPA  },
    '{1'b1, 1'b0, 1'b0, 16'hABCD, AN, OEA,   DPA  },
    '{1'b0, 1'b1, 1'b0, 16'h0000, AP, 8'h00, 8'h00},
    '{1'b1, 1'b1, 1'b0, 16'h5A3C, AN, OEA,   DPA  },
    '{1'b0, 1'b1, 1'b1, 16'h0000, AP, 8'h00, 8'h00},
    '{1'b0, 1'b1, 1'b0, 16'h0000, AP, 8'h00, 8'h00},
    '{1'b0, 1'b0, 1'b1, 16'h0000, AN, 8'h00, 8'h00},
    '{1'b1, 1'b0, 1'b1, 16'hFF00, AN, OEA,   DPA  },
    '{1'b1, 1'b1, 1'b0, 16'h00FF, AN, OEA,   DPA  },
    '{1'b0, 1'b0, 1'b0, 16'h0000, AN, 8'h00, 8'h00}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ale_off_i = 1'b0;
  logic        req_i = 1'b0;
  logic [15:0] addr_i = 16'h0;
  logic        ale_o;
  logic        ad_oe_o;
  logic [7:0]  ad_addr_o;
  logic [7:0]  addr_hi_o;
  logic        data_phase_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mux_bus_timing u0 (
    .clk_i, .rst_ni, .ale_off_i, .req_i, .addr_i,
    .ale_o, .ad_oe_o, .ad_addr_o, .addr_hi_o, .data_phase_o
  );

  task automatic check(string tag, logic [18:0] act, logic [18:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0t act={ale,oe,dp,lo,hi}=%h exp=%h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [18:0] outs();
    return {ale_o, ad_oe_o, data_phase_o, ad_addr_o, addr_hi_o};
  endfunction

  task automatic apply(vec_t v);
    req_i = v.req; ale_off_i = v.off; addr_i = v.addr;
  endtask

  // Entered just after a negedge in half-clock 0 of the cycle described by cur
  task automatic run_cycle(vec_t cur, vec_t nxt);
    string tag;
    if (cur.glitch)             tag = "R5";
    else if (cur.req && cur.off) tag = "R4";
    else if (cur.req)           tag = "R6 R7 R8 R9";
    else if (cur.off)           tag = "R3";
    else                        tag = "R1";
    for (int h = 0; h < 8; h++) begin
      logic oe_e;
      oe_e = cur.oe_m[h];
      check(tag, outs(), {cur.ale_m[h], oe_e, cur.dp_m[h],
                          oe_e ? cur.addr[7:0] : 8'h00,
                          cur.req ? cur.addr[15:8] : 8'h00});
      if (h == 3 && cur.glitch) begin
        req_i = ~cur.req; ale_off_i = ~cur.off; addr_i = ~cur.addr;
      end
      if (h == 7) apply(nxt);
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    vec_t cur;
    // R2: reset values held while rst_ni is low
    repeat (3) @(negedge clk_i);
    check("R2", outs(), {1'b1, 1'b0, 1'b0, 8'h00, 8'h00});
    rst_ni = 1'b1;
    // R2: first cycle after release is idle with a normal pulse (checked in run_cycle)
    cur = IDLE;
    for (int i = 0; i < NV; i++) begin
      run_cycle(cur, VEC[i]);
      cur = VEC[i];
    end
    run_cycle(cur, '{1'b1, 1'b0, 1'b0, 16'h7E81, AN, OEA, DPA});
    // R2: asynchronous reset in the middle of an access
    repeat (4) begin @(posedge clk_i); @(negedge clk_i); end
    check("R7", outs(), {1'b0, 1'b0, 1'b1, 8'h00, 8'h7E});
    rst_ni = 1'b0;
    #1;
    check("R2", outs(), {1'b1, 1'b0, 1'b0, 8'h00, 8'h00});
    apply(IDLE);
    repeat (5) @(negedge clk_i);
    check("R2", outs(), {1'b1, 1'b0, 1'b0, 8'h00, 8'h00});
    rst_ni = 1'b1;
    run_cycle(IDLE, IDLE);
    run_cycle(IDLE, IDLE);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule